// File: doc/BRIEF.md
# Keypad Entry Register

This block assembles the number a user is typing on a calculator keypad. Key events arrive one per cycle from a keyboard scanner: a digit, the decimal point, a minus, a clear of the current entry, or a clear of everything. The block holds the operand as packed BCD, right-justified, with a count of digits after the decimal point and a sign flag. Arithmetic and display logic read these outputs directly.

Arithmetic logic raises a start-new-entry pulse when it has taken the operand. The old value stays on the outputs until the user presses the next digit or the decimal point. That key then starts a fresh operand. A minus pressed in between makes the coming operand negative. All outputs are registered and change one clock after the event that caused the change.

Top module: `calc_entry_reg`

## Requirements
- R1: The operand holds at most DIGITS (default 8) decimal digits. A digit key pressed while the entry is full changes no output.
- R2: An accepted digit enters the least significant BCD nibble (bits 3:0), and every earlier digit moves one nibble towards the most significant end. Every nibble is always a value from 0 to 9.
- R3: The first decimal-point key in an entry fixes the point position. Later decimal-point keys in the same entry are ignored.
- R4: `point_idx` counts the digits accepted after the decimal point. It is 0 when no point has been entered.
- R5: A zero digit pressed while the entry holds no digit and has no point leaves the operand at zero and `entry_len` at 0, so it uses none of the capacity.
- R6: A minus key pressed while `entry_len` is 0 sets `negative`. A minus key pressed once digits are stored is ignored.
- R7: Clear-entry (code 12) zeroes the operand, `point_idx`, `entry_len` and `negative`, and cancels a pending new-entry request.
- R8: Full clear (code 13) returns every output and internal flag to zero. Synchronous reset does the same.
- R9: After a `new_entry` pulse the outputs hold until the next digit or point key. That key starts a new operand containing only that digit (or an empty operand with a point). The new operand is negative only if a minus key came between the pulse and that key. A pulse in the same cycle as a key applies to that key.
- R10: Key codes are 0 to 9 for digits, 10 for point, 11 for minus, 12 for clear-entry and 13 for full clear. Codes 14 and 15, and any cycle with `key_valid` low, change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up clear) |
| key_valid | input | 1 | A key event is present this cycle |
| key_code | input | 4 | Key code, encoded as in R10 |
| new_entry | input | 1 | Start-new-entry pulse from the arithmetic logic |
| operand | output | DIGITS*4 | Packed BCD operand, least significant digit in bits 3:0 |
| point_idx | output | CW | Digits to the right of the decimal point |
| negative | output | 1 | Operand sign |
| entry_len | output | CW | Number of digits stored |

## Verification
The bench builds the block with DIGITS = 8, the same capacity the keypad uses. At that capacity a random run reaches a full register and dropped ninth digits many times between clears. Clear keys are weighted low so that long entries with a point placed late or early occur often. Directed sequences cover leading zeros, the position of a minus before and after the first digit, and a new-entry pulse that coincides with a key. These are the places where the order of events decides the result.

// File: rtl/calc_entry_pkg.sv
package calc_entry_pkg;

  localparam logic [3:0] KC_POINT = 4'd10;
  localparam logic [3:0] KC_MINUS = 4'd11;
  localparam logic [3:0] KC_CE    = 4'd12;
  localparam logic [3:0] KC_CA    = 4'd13;

  typedef struct packed {
    logic       digit;
    logic [3:0] val;
    logic       point;
    logic       minus;
    logic       clr_entry;
    logic       clr_all;
  } key_ev_t;

endpackage

// File: rtl/entry_decode.sv
module entry_decode
  import calc_entry_pkg::*;
(
  input  logic       key_valid,
  input  logic [3:0] key_code,
  output key_ev_t    ev
);

  always_comb begin
    ev           = '0;
    ev.val       = key_code;
    ev.digit     = key_valid && (key_code <= 4'd9);
    ev.point     = key_valid && (key_code == KC_POINT);
    ev.minus     = key_valid && (key_code == KC_MINUS);
    ev.clr_entry = key_valid && (key_code == KC_CE);
    ev.clr_all   = key_valid && (key_code == KC_CA);
  end

endmodule

// File: rtl/bcd_shift.sv
module bcd_shift #(
  parameter int DIGITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                start,
  input  logic                shift,
  input  logic [3:0]          din,
  output logic [DIGITS*4-1:0] q
);

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    if (i == 0) begin : g_lsd
      always_ff @(posedge clk) begin
        if (rst || clr)        q[3:0] <= 4'd0;
        else if (start || shift) q[3:0] <= din;
      end
    end else begin : g_up
      always_ff @(posedge clk) begin
        if (rst || clr || start) q[i*4 +: 4] <= 4'd0;
        else if (shift)          q[i*4 +: 4] <= q[(i-1)*4 +: 4];
      end
    end

    p_nibble_bcd_r2: assert property (@(posedge clk) disable iff (rst)
      q[i*4 +: 4] <= 4'd9);
  end

  p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
    (shift && !clr && !start) |=> q[3:0] == $past(din));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0);

endmodule

// File: rtl/entry_ctrl.sv
module entry_ctrl
  import calc_entry_pkg::*;
#(
  parameter int DIGITS = 8,
  localparam int CW = $clog2(DIGITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  key_ev_t       ev,
  input  logic          new_entry,
  output logic          sh_clr,
  output logic          sh_start,
  output logic          sh_shift,
  output logic [CW-1:0] count,
  output logic [CW-1:0] dp_idx,
  output logic          neg
);

  localparam logic [CW-1:0] FULL = CW'(DIGITS);

  logic          dp_set, fresh, armed;
  logic [CW-1:0] n_count, n_dp_idx;
  logic          n_neg, n_dp_set, n_fresh, n_armed;
  logic          fresh_eff;

  assign fresh_eff = fresh | new_entry;

  always_comb begin
    n_count  = count;
    n_dp_idx = dp_idx;
    n_neg    = neg;
    n_dp_set = dp_set;
    n_fresh  = fresh;
    n_armed  = armed;
    sh_clr   = 1'b0;
    sh_start = 1'b0;
    sh_shift = 1'b0;
    if (ev.clr_all || ev.clr_entry) begin
      sh_clr   = 1'b1;
      n_count  = '0;
      n_dp_idx = '0;
      n_neg    = 1'b0;
      n_dp_set = 1'b0;
      n_fresh  = 1'b0;
      n_armed  = 1'b0;
    end else if (ev.digit) begin
      if (fresh_eff) begin
        sh_start = 1'b1;
        n_count  = (ev.val != 4'd0) ? CW'(1) : '0;
        n_dp_idx = '0;
        n_dp_set = 1'b0;
        n_neg    = armed && !new_entry;
        n_fresh  = 1'b0;
        n_armed  = 1'b0;
      end else if (count == FULL) begin
        sh_shift = 1'b0;
      end else if (count == '0 && !dp_set && ev.val == 4'd0) begin
        sh_shift = 1'b0;
      end else begin
        sh_shift = 1'b1;
        n_count  = count + CW'(1);
        if (dp_set) n_dp_idx = dp_idx + CW'(1);
      end
    end else if (ev.point) begin
      if (fresh_eff) begin
        sh_clr   = 1'b1;
        n_count  = '0;
        n_dp_idx = '0;
        n_dp_set = 1'b1;
        n_neg    = armed && !new_entry;
        n_fresh  = 1'b0;
        n_armed  = 1'b0;
      end else if (!dp_set) begin
        n_dp_set = 1'b1;
      end
    end else if (ev.minus) begin
      if (fresh_eff) begin
        n_fresh = 1'b1;
        n_armed = 1'b1;
      end else if (count == '0) begin
        n_neg = 1'b1;
      end
    end else if (new_entry) begin
      n_fresh = 1'b1;
      n_armed = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      dp_idx <= '0;
      neg    <= 1'b0;
      dp_set <= 1'b0;
      fresh  <= 1'b0;
      armed  <= 1'b0;
    end else begin
      count  <= n_count;
      dp_idx <= n_dp_idx;
      neg    <= n_neg;
      dp_set <= n_dp_set;
      fresh  <= n_fresh;
      armed  <= n_armed;
    end
  end

  p_cap_r1: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);

  p_full_drop_r1: assert property (@(posedge clk) disable iff (rst)
    (ev.digit && !fresh_eff && count == FULL) |=> ($stable(count) && $stable(dp_idx)));

  p_point_once_r3: assert property (@(posedge clk) disable iff (rst)
    (ev.point && dp_set && !fresh_eff) |=> $stable(dp_idx));

  p_idx_within_r4: assert property (@(posedge clk) disable iff (rst)
    dp_idx <= count);

  p_lead_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (ev.digit && ev.val == 4'd0 && !fresh_eff && count == '0 && !dp_set) |=> count == '0);

  p_late_minus_r6: assert property (@(posedge clk) disable iff (rst)
    (ev.minus && !fresh_eff && count != '0) |=> $stable(neg));

  p_full_clear_r8: assert property (@(posedge clk) disable iff (rst)
    ev.clr_all |=> (count == '0 && dp_idx == '0 && !neg && !fresh && !armed));

endmodule

// File: rtl/calc_entry_reg.sv
module calc_entry_reg
  import calc_entry_pkg::*;
#(
  parameter int DIGITS = 8,
  localparam int CW = $clog2(DIGITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                key_valid,
  input  logic [3:0]          key_code,
  input  logic                new_entry,
  output logic [DIGITS*4-1:0] operand,
  output logic [CW-1:0]       point_idx,
  output logic                negative,
  output logic [CW-1:0]       entry_len
);

  key_ev_t ev;
  logic    sh_clr, sh_start, sh_shift;

  entry_decode u_dec (
    .key_valid (key_valid),
    .key_code  (key_code),
    .ev        (ev)
  );

  entry_ctrl #(.DIGITS(DIGITS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .new_entry (new_entry),
    .sh_clr    (sh_clr),
    .sh_start  (sh_start),
    .sh_shift  (sh_shift),
    .count     (entry_len),
    .dp_idx    (point_idx),
    .neg       (negative)
  );

  bcd_shift #(.DIGITS(DIGITS)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .clr   (sh_clr),
    .start (sh_start),
    .shift (sh_shift),
    .din   (ev.val),
    .q     (operand)
  );

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!key_valid && !new_entry) |=> ($stable(operand) && $stable(entry_len) && $stable(negative)));

endmodule

// File: tb/sim_calc_entry_reg.sv
`timescale 1ns/1ps
module sim_calc_entry_reg;

  localparam int ND = 8;
  localparam int CW = $clog2(ND + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          key_valid = 1'b0;
  logic [3:0]    key_code = 4'd0;
  logic          new_entry = 1'b0;
  logic [ND*4-1:0] operand;
  logic [CW-1:0] point_idx;
  logic          negative;
  logic [CW-1:0] entry_len;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [ND*4-1:0] m_op;
  int m_cnt, m_idx;
  bit m_neg, m_dp, m_fresh, m_armed;

  always #2.5 clk = ~clk;

  calc_entry_reg #(.DIGITS(ND)) u0 (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_code(key_code),
    .new_entry(new_entry), .operand(operand), .point_idx(point_idx),
    .negative(negative), .entry_len(entry_len)
  );

  task automatic m_clear();
    m_op = '0; m_cnt = 0; m_idx = 0;
    m_neg = 0; m_dp = 0; m_fresh = 0; m_armed = 0;
  endtask

  task automatic m_apply(input bit v, input logic [3:0] c, input bit ne);
    bit fe;
    fe = m_fresh || ne;
    if (v && (c == 4'd12 || c == 4'd13)) begin
      m_clear();
    end else if (v && c <= 4'd9) begin
      if (fe) begin
        m_op = '0; m_op[3:0] = c;
        m_cnt = (c != 0) ? 1 : 0; m_idx = 0; m_dp = 0;
        m_neg = m_armed && !ne; m_fresh = 0; m_armed = 0;
      end else if (m_cnt < ND && !(m_cnt == 0 && !m_dp && c == 4'd0)) begin
        m_op = {m_op[ND*4-5:0], c};
        m_cnt++;
        if (m_dp) m_idx++;
      end
    end else if (v && c == 4'd10) begin
      if (fe) begin
        m_op = '0; m_cnt = 0; m_idx = 0; m_dp = 1;
        m_neg = m_armed && !ne; m_fresh = 0; m_armed = 0;
      end else m_dp = 1;
    end else if (v && c == 4'd11) begin
      if (fe) begin m_fresh = 1; m_armed = 1; end
      else if (m_cnt == 0) m_neg = 1;
    end else if (ne) begin
      m_fresh = 1; m_armed = 0;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (operand !== m_op || point_idx !== CW'(m_idx) || negative !== m_neg ||
        entry_len !== CW'(m_cnt)) begin
      errors++;
      $display("FAIL %s: got op=%h idx=%0d neg=%0b len=%0d, expected op=%h idx=%0d neg=%0b len=%0d",
               tag, operand, point_idx, negative, entry_len, m_op, m_idx, m_neg, m_cnt);
    end
  endtask

  task automatic expect_op(input logic [ND*4-1:0] op, input int idx, input bit ng, input string tag);
    checks++;
    if (operand !== op || point_idx !== CW'(idx) || negative !== ng) begin
      errors++;
      $display("FAIL %s: got op=%h idx=%0d neg=%0b, expected op=%h idx=%0d neg=%0b",
               tag, operand, point_idx, negative, op, idx, ng);
    end
  endtask

  task automatic step(input bit v, input logic [3:0] c, input bit ne, input string tag);
    @(negedge clk);
    key_valid = v; key_code = c; new_entry = ne;
    @(posedge clk); #1;
    m_apply(v, c, ne);
    key_valid = 1'b0; new_entry = 1'b0;
    compare(tag);
  endtask

  task automatic key(input logic [3:0] c, input string tag);
    step(1'b1, c, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 compare("R8 reset");

    // R1 R2: nine digits, the ninth dropped
    for (int i = 1; i <= 9; i++) key(4'(i), "R2 shift");
    expect_op(32'h12345678, 0, 0, "R1 ninth digit ignored");

    // R8 full clear
    key(4'd13, "R8 full clear");
    // R3 R4: 1 . 2 . 3
    key(4'd1, "R2"); key(4'd10, "R3"); key(4'd2, "R4");
    key(4'd10, "R3 second point"); key(4'd3, "R4");
    expect_op(32'h00000123, 2, 0, "R3 R4 first point kept");

    // R7 clear entry, R5 leading zeros
    key(4'd12, "R7 clear entry");
    key(4'd0, "R5"); key(4'd0, "R5"); key(4'd5, "R5");
    expect_op(32'h00000005, 0, 0, "R5 leading zeros");
    // R4: point then zeros count after point
    key(4'd12, "R7"); key(4'd10, "R4"); key(4'd0, "R4"); key(4'd7, "R4");
    expect_op(32'h00000007, 2, 0, "R4 zeros after point");

    // R6 minus before and after first digit
    key(4'd12, "R7"); key(4'd11, "R6 early minus"); key(4'd2, "R6");
    expect_op(32'h00000002, 0, 1, "R6 negative");
    key(4'd11, "R6 late minus"); key(4'd12, "R7 clears sign");
    key(4'd3, "R6"); key(4'd11, "R6 late minus");
    expect_op(32'h00000003, 0, 0, "R6 minus after digit ignored");

    // R9 new entry: value held, minus arms sign
    step(1'b0, 4'd0, 1'b1, "R9 pulse holds");
    expect_op(32'h00000003, 0, 0, "R9 held value");
    key(4'd11, "R9 armed minus");
    expect_op(32'h00000003, 0, 0, "R9 still held");
    key(4'd4, "R9 fresh digit");
    expect_op(32'h00000004, 0, 1, "R9 new negative operand");
    step(1'b1, 4'd9, 1'b1, "R9 same-cycle pulse");
    expect_op(32'h00000009, 0, 0, "R9 pulse with key");
    step(1'b0, 4'd0, 1'b1, "R9"); key(4'd12, "R7 cancels pending");
    key(4'd6, "R7"); key(4'd1, "R7");
    expect_op(32'h00000061, 0, 0, "R7 pending cancelled");

    // R10 invalid codes and idle cycles
    key(4'd14, "R10 code 14"); key(4'd15, "R10 code 15");
    step(1'b0, 4'd5, 1'b0, "R10 valid low");
    expect_op(32'h00000061, 0, 0, "R10 ignored");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [3:0] c;
      bit v, ne;
      r = int'($urandom % 100);
      v = 1'b1;
      if (r < 55)      c = 4'($urandom % 10);
      else if (r < 65) c = 4'd10;
      else if (r < 72) c = 4'd11;
      else if (r < 75) c = 4'd12;
      else if (r < 77) c = 4'd13;
      else if (r < 82) c = 4'(14 + ($urandom % 2));
      else begin c = 4'($urandom % 16); v = 1'b0; end
      ne = (($urandom % 100) < 8);
      step(v, c, ne, "R1-random");
    end

    // reset mid-entry
    key(4'd7, "R8"); @(negedge clk); rst = 1'b1; @(posedge clk); #1;
    rst = 1'b0; m_clear(); compare("R8 reset mid entry");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule